// File: doc/BRIEF.md
# Half-Duplex Buffered Serial Flash Master

This block is a serial master for flash memories and other devices that talk in one direction at a time. Software fills a command word and a data buffer of up to 32 bytes through a small 32-bit register bus. It then writes the bit counts for three phases into one register and sets a start bit. The three phases are command, outgoing data and incoming data. The block shifts the command bits first, then the outgoing data bits. After that it shifts in the incoming bits and stores them back into the same data buffer. Software polls a busy flag until the shift is done and then reads the captured bytes.

The serial clock comes from a programmable divider of the system clock. Only clock mode 0 is supported: the clock idles low, the output bit changes on the falling edge and the input bit is sampled on the rising edge. A configuration bit selects which end of each byte is sent first. Device selects are active low and are driven straight from a register. A select therefore stays asserted across a series of separate transfers, which is how a long flash command is sent in pieces.

Top module: `spi_hd_master`

## Requirements
- R1: After reset every register reads zero, all `cs_n` lines are high, `sck` is low and `mosi` is low.
- R2: Register offsets on `bus_addr` are: control 0x00, command word 0x04, data buffer 0x08 to 0x24, configuration 0x28, phase counts 0x2C, device select 0x38. The command word, the buffer words, the configuration fields and the count fields read back as written. In the buffer, byte k sits in word 0x08+4*(k/4) at bits [8*(k%4)+7 : 8*(k%4)].
- R3: A write to 0x00 with bit 8 set starts a transfer. Bit 16 of 0x00 then reads 1 until the transfer ends. Bit 8 always reads 0.
- R4: The phase-count register holds the command bit count in [29:24] (0 to 32), the read bit count in [20:12] and the write bit count in [8:0]. The phases run in the order command, write, read, and a phase with a zero count is skipped. A start with all three counts zero leaves busy clear and produces no clock.
- R5: Command bits are taken from the byte in bits [31:24] first, then [23:16], and so on down the word.
- R6: Write-phase bits are taken from buffer byte 0 first, then byte 1, and so on.
- R7: Read-phase bits are sampled on the rising `sck` edge. They fill the buffer from byte 0 upward, in arrival order. Bits beyond the last buffer byte are dropped and do not wrap around.
- R8: With divider field D in configuration bits [27:16], one `sck` period lasts D+2 system clocks: low for the ceiling of half a period, high for the rest. A transfer of N bits keeps busy high for exactly N*(D+2) clocks, and busy falls together with the last falling `sck` edge.
- R9: Configuration bit 3 at 0 sends and stores each byte most significant bit first. At 1 it uses least significant bit first. Other configuration bits besides the divider read 0.
- R10: `sck` is low whenever the block is idle, and `mosi` holds steady while `sck` is high.
- R11: A start write while busy is set has no effect: the running transfer keeps its length and bit stream.
- R12: Bit i of the select register drives `cs_n[i]` low while set. `cs_n` changes only on a write to 0x38 and never because of a transfer.
- R13: `mosi` is low when idle and during the read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |
| cs_n | output | NUM_CS | Active-low device selects |

## Verification
If the bit index, the phase boundaries or the byte-lane selection goes wrong, the `mosi` value sampled at some rising `sck` edge is wrong. The scoreboard catches this on that edge, which is within one serial period of the fault. A wrong period or a wrong end-of-transfer decision changes the number of clocks for which busy reads high, so it shows when the transfer ends. A capture into the wrong byte or bit, or a wrap beyond the buffer, stays hidden until the buffer is read back after the transfer. For that reason every read test compares all buffer words with values the bench derives from the pattern that its device model shifts in.

// File: rtl/spi_hd_pkg.sv
package spi_hd_pkg;
   localparam int unsigned BUS_AW = 6;

   localparam logic [BUS_AW-1:0] OFS_CTRL = 6'h00;
   localparam logic [BUS_AW-1:0] OFS_CMD  = 6'h04;
   localparam logic [BUS_AW-1:0] OFS_BUF0 = 6'h08;
   localparam logic [BUS_AW-1:0] OFS_CFG  = 6'h28;
   localparam logic [BUS_AW-1:0] OFS_CNT  = 6'h2C;
   localparam logic [BUS_AW-1:0] OFS_SEL  = 6'h38;

   localparam int unsigned GO_BIT    = 8;
   localparam int unsigned BUSY_BIT  = 16;
   localparam int unsigned ORDER_BIT = 3;
   localparam int unsigned DIV_LSB   = 16;
   localparam int unsigned DIV_MAXW  = 12;
   localparam int unsigned NCMD_LSB  = 24;
   localparam int unsigned NRD_LSB   = 12;
   localparam int unsigned NWR_LSB   = 0;

   // total bit index width: 63 + 511 + 511 fits in 11 bits
   localparam int unsigned IDX_W = 11;

   typedef struct packed {
      logic [5:0] cmd_bits;
      logic [8:0] rd_bits;
      logic [8:0] wr_bits;
   } phase_cnt_t;
endpackage

// File: rtl/spi_hd_sck_gen.sv
module spi_hd_sck_gen #(
   parameter int unsigned DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             sck,
   output logic             rise_tick,
   output logic             fall_tick
);
   localparam int unsigned PW = DIV_W + 1;

   logic [PW-1:0] cnt_q;
   logic [PW-1:0] period;
   logic [PW-1:0] lo_len;

   assign period    = PW'(div) + PW'(2);
   assign lo_len    = period - (period >> 1);
   assign rise_tick = run && (cnt_q == lo_len - PW'(1));
   assign fall_tick = run && (cnt_q == period - PW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         sck   <= 1'b0;
      end else if (!run) begin
         cnt_q <= '0;
         sck   <= 1'b0;
      end else begin
         cnt_q <= fall_tick ? '0 : cnt_q + PW'(1);
         if (rise_tick)      sck <= 1'b1;
         else if (fall_tick) sck <= 1'b0;
      end
   end
endmodule

// File: rtl/spi_hd_regfile.sv
module spi_hd_regfile
   import spi_hd_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 32,
   parameter int unsigned NUM_CS     = 2,
   parameter int unsigned DIV_W      = 12,
   localparam int unsigned BYTE_IW   = $clog2(DATA_BYTES),
   localparam int unsigned WORDS     = DATA_BYTES / 4,
   localparam int unsigned WORD_IW   = $clog2(WORDS)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_sel,
   input  logic                    bus_we,
   input  logic [BUS_AW-1:0]       bus_addr,
   input  logic [31:0]             bus_wdata,
   output logic [31:0]             bus_rdata,
   input  logic                    busy,
   output logic                    start_req,
   output logic [31:0]             cmd_word,
   output logic [DATA_BYTES*8-1:0] buf_flat,
   output logic [DIV_W-1:0]        cfg_div,
   output logic                    cfg_lsb,
   output phase_cnt_t              counts,
   output logic [NUM_CS-1:0]       sel_reg,
   input  logic                    cap_we,
   input  logic [BYTE_IW-1:0]      cap_byte,
   input  logic [2:0]              cap_bit,
   input  logic                    cap_val
);
   logic [7:0]        buf_q [DATA_BYTES];
   logic              wr_en;
   logic              in_buf;
   logic [BUS_AW-1:0] buf_off;
   logic [WORD_IW-1:0] word_idx;

   assign wr_en     = bus_sel && bus_we;
   assign start_req = wr_en && (bus_addr == OFS_CTRL) && bus_wdata[GO_BIT];
   assign buf_off   = bus_addr - OFS_BUF0;
   assign in_buf    = (bus_addr >= OFS_BUF0) &&
                      (bus_addr < OFS_BUF0 + BUS_AW'(DATA_BYTES));
   assign word_idx  = buf_off[WORD_IW+1:2];

   for (genvar b = 0; b < DATA_BYTES; b++) begin : g_flat
      assign buf_flat[8*b +: 8] = buf_q[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DATA_BYTES; i++) buf_q[i] <= '0;
         cmd_word <= '0;
         cfg_div  <= '0;
         cfg_lsb  <= 1'b0;
         counts   <= '0;
         sel_reg  <= '0;
      end else begin
         if (wr_en) begin
            if (in_buf) begin
               for (int l = 0; l < 4; l++)
                  buf_q[{word_idx, 2'(l)}] <= bus_wdata[8*l +: 8];
            end
            unique case (bus_addr)
               OFS_CMD: cmd_word <= bus_wdata;
               OFS_CFG: begin
                  cfg_div <= bus_wdata[DIV_LSB +: DIV_W];
                  cfg_lsb <= bus_wdata[ORDER_BIT];
               end
               OFS_CNT: begin
                  counts.cmd_bits <= bus_wdata[NCMD_LSB +: 6];
                  counts.rd_bits  <= bus_wdata[NRD_LSB  +: 9];
                  counts.wr_bits  <= bus_wdata[NWR_LSB  +: 9];
               end
               OFS_SEL: sel_reg <= bus_wdata[NUM_CS-1:0];
               default: ;
            endcase
         end
         if (cap_we) buf_q[cap_byte][cap_bit] <= cap_val;
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (in_buf) begin
         for (int l = 0; l < 4; l++)
            bus_rdata[8*l +: 8] = buf_q[{word_idx, 2'(l)}];
      end else begin
         unique case (bus_addr)
            OFS_CTRL: bus_rdata[BUSY_BIT] = busy;
            OFS_CMD:  bus_rdata = cmd_word;
            OFS_CFG: begin
               bus_rdata[DIV_LSB +: DIV_W] = cfg_div;
               bus_rdata[ORDER_BIT]        = cfg_lsb;
            end
            OFS_CNT: begin
               bus_rdata[NCMD_LSB +: 6] = counts.cmd_bits;
               bus_rdata[NRD_LSB  +: 9] = counts.rd_bits;
               bus_rdata[NWR_LSB  +: 9] = counts.wr_bits;
            end
            OFS_SEL: bus_rdata[NUM_CS-1:0] = sel_reg;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/spi_hd_sequencer.sv
module spi_hd_sequencer
   import spi_hd_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 32,
   parameter int unsigned DIV_W      = 12,
   localparam int unsigned BYTE_IW   = $clog2(DATA_BYTES)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    start_req,
   input  phase_cnt_t              counts,
   input  logic                    cfg_lsb,
   input  logic [DIV_W-1:0]        cfg_div,
   input  logic [31:0]             cmd_word,
   input  logic [DATA_BYTES*8-1:0] buf_flat,
   input  logic                    rise_tick,
   input  logic                    fall_tick,
   input  logic                    miso,
   output logic                    busy,
   output logic [DIV_W-1:0]        run_div,
   output logic                    mosi,
   output logic                    cap_we,
   output logic [BYTE_IW-1:0]      cap_byte,
   output logic [2:0]              cap_bit,
   output logic                    cap_val
);
   logic [5:0]       ncmd_q;
   logic [8:0]       nwr_q;
   logic [IDX_W-1:0] tot_q, bidx_q, total_in;
   logic             lsb_q;
   logic             in_cmd, in_wr, in_rd;
   logic [IDX_W-1:0] wr_end, wr_off, rd_off;
   logic [2:0]       cmd_sel, wr_sel, rd_sel;
   logic [IDX_W-4:0] wr_byte, rd_byte;
   logic             wr_ok, rd_ok, cmd_b, wr_b;

   function automatic logic [2:0] pick(input logic [2:0] j, input logic lsb);
      return lsb ? j : 3'd7 - j;
   endfunction

   assign total_in = IDX_W'(counts.cmd_bits) + IDX_W'(counts.wr_bits) +
                     IDX_W'(counts.rd_bits);
   assign wr_end   = IDX_W'(ncmd_q) + IDX_W'(nwr_q);
   assign in_cmd   = bidx_q < IDX_W'(ncmd_q);
   assign in_wr    = !in_cmd && (bidx_q < wr_end);
   assign in_rd    = !in_cmd && !in_wr;
   assign wr_off   = bidx_q - IDX_W'(ncmd_q);
   assign rd_off   = bidx_q - wr_end;

   assign cmd_sel  = pick(bidx_q[2:0], lsb_q);
   assign wr_sel   = pick(wr_off[2:0], lsb_q);
   assign rd_sel   = pick(rd_off[2:0], lsb_q);
   assign wr_byte  = wr_off[IDX_W-1:3];
   assign rd_byte  = rd_off[IDX_W-1:3];
   assign wr_ok    = wr_byte < (IDX_W-3)'(DATA_BYTES);
   assign rd_ok    = rd_byte < (IDX_W-3)'(DATA_BYTES);

   // command lanes run from the top byte down: lane = 3 - byte number
   assign cmd_b = cmd_word[{~bidx_q[4:3], cmd_sel}];
   assign wr_b  = wr_ok && buf_flat[{wr_byte[BYTE_IW-1:0], wr_sel}];
   assign mosi  = busy && (in_cmd ? cmd_b : (in_wr && wr_b));

   assign cap_we   = busy && rise_tick && in_rd && rd_ok;
   assign cap_byte = rd_byte[BYTE_IW-1:0];
   assign cap_bit  = rd_sel;
   assign cap_val  = miso;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         bidx_q  <= '0;
         tot_q   <= '0;
         ncmd_q  <= '0;
         nwr_q   <= '0;
         lsb_q   <= 1'b0;
         run_div <= '0;
      end else if (!busy) begin
         if (start_req && (total_in != '0)) begin
            busy    <= 1'b1;
            bidx_q  <= '0;
            tot_q   <= total_in;
            ncmd_q  <= counts.cmd_bits;
            nwr_q   <= counts.wr_bits;
            lsb_q   <= cfg_lsb;
            run_div <= cfg_div;
         end
      end else if (fall_tick) begin
         if (bidx_q == tot_q - IDX_W'(1)) begin
            busy   <= 1'b0;
            bidx_q <= '0;
         end else begin
            bidx_q <= bidx_q + IDX_W'(1);
         end
      end
   end
endmodule

// File: rtl/spi_hd_master.sv
module spi_hd_master
   import spi_hd_pkg::*;
#(
   parameter int unsigned DATA_BYTES = 32,
   parameter int unsigned NUM_CS     = 2,
   parameter int unsigned DIV_W      = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [5:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sck,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n
);
   localparam int unsigned BYTE_IW = $clog2(DATA_BYTES);

   if (DATA_BYTES < 8 || (DATA_BYTES & (DATA_BYTES - 1)) != 0 ||
       32'(OFS_BUF0) + DATA_BYTES > 32'(OFS_CFG)) begin : g_bad_bytes
      $error("DATA_BYTES must be a power of two from 8 to 32");
   end
   if (DIV_W < 1 || DIV_W > DIV_MAXW) begin : g_bad_div
      $error("DIV_W must be 1 to 12");
   end
   if (NUM_CS < 1 || NUM_CS > 8) begin : g_bad_cs
      $error("NUM_CS must be 1 to 8");
   end

   logic                    busy_w, start_w, lsb_w;
   logic                    rise_w, fall_w;
   logic [31:0]             cmd_w;
   logic [DATA_BYTES*8-1:0] buf_w;
   logic [DIV_W-1:0]        div_cfg_w, div_run_w;
   phase_cnt_t              cnt_w;
   logic [NUM_CS-1:0]       sel_w;
   logic                    cap_we_w, cap_val_w;
   logic [BYTE_IW-1:0]      cap_byte_w;
   logic [2:0]              cap_bit_w;

   spi_hd_regfile #(
      .DATA_BYTES(DATA_BYTES), .NUM_CS(NUM_CS), .DIV_W(DIV_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy_w), .start_req(start_w), .cmd_word(cmd_w),
      .buf_flat(buf_w), .cfg_div(div_cfg_w), .cfg_lsb(lsb_w),
      .counts(cnt_w), .sel_reg(sel_w),
      .cap_we(cap_we_w), .cap_byte(cap_byte_w), .cap_bit(cap_bit_w),
      .cap_val(cap_val_w)
   );

   spi_hd_sequencer #(
      .DATA_BYTES(DATA_BYTES), .DIV_W(DIV_W)
   ) seq_i (
      .clk(clk), .rst_n(rst_n), .start_req(start_w), .counts(cnt_w),
      .cfg_lsb(lsb_w), .cfg_div(div_cfg_w), .cmd_word(cmd_w),
      .buf_flat(buf_w), .rise_tick(rise_w), .fall_tick(fall_w),
      .miso(miso), .busy(busy_w), .run_div(div_run_w), .mosi(mosi),
      .cap_we(cap_we_w), .cap_byte(cap_byte_w), .cap_bit(cap_bit_w),
      .cap_val(cap_val_w)
   );

   spi_hd_sck_gen #(
      .DIV_W(DIV_W)
   ) sck_i (
      .clk(clk), .rst_n(rst_n), .run(busy_w), .div(div_run_w),
      .sck(sck), .rise_tick(rise_w), .fall_tick(fall_w)
   );

   for (genvar c = 0; c < NUM_CS; c++) begin : g_sel
      assign cs_n[c] = ~sel_w[c];
   end
endmodule

// File: rtl/spi_hd_master_chk.sv
module spi_hd_master_chk
   import spi_hd_pkg::*;
#(
   parameter int unsigned NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [5:0]        bus_addr,
   input logic [31:0]       bus_rdata,
   input logic              sck,
   input logic              mosi,
   input logic [NUM_CS-1:0] cs_n,
   input logic              busy,
   input logic              start_req
);
   // R10
   idle_sck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);

   // R13
   idle_mosi_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mosi);

   // R10
   mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));

   // R11
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_req));

   // R8
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $fell(sck));

   // R3
   go_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && bus_addr == OFS_CTRL) |-> !bus_rdata[GO_BIT]);

   // R12
   sel_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cs_n) |-> $past(bus_sel && bus_we && bus_addr == OFS_SEL));
endmodule

bind spi_hd_master spi_hd_master_chk #(.NUM_CS(NUM_CS)) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
   .cs_n(cs_n), .busy(busy_w), .start_req(start_w)
);

// File: tb/spi_hd_master_tb_top.sv
`timescale 1ns/1ps
module spi_hd_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_we = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sck, mosi, miso;
   logic [1:0]  cs_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   string cur_tag = "R5";

   logic [7:0]  tb_buf [32];
   logic        exp_q [$];
   logic [63:0] slv_pat = 64'hC3A5_1E96_F00D_5A3C;
   int          slv_cnt;
   logic        slv_clr = 1'b0;

   always #2 clk = ~clk;

   spi_hd_master dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
   );

   // device model: one new bit per falling sck edge, 60-bit repeating pattern
   always @(negedge sck or posedge slv_clr)
      if (slv_clr) slv_cnt <= 0; else slv_cnt <= slv_cnt + 1;
   assign miso = slv_pat[63 - (slv_cnt % 60)];

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // monitor: every rising sck consumes one expected mosi bit
   always @(posedge sck) begin
      if (exp_q.size() == 0)
         check(1'b0, cur_tag, "unexpected sck edge", 32'(mosi), 32'hx);
      else begin
         automatic logic e = exp_q.pop_front();
         check(mosi === e, cur_tag, "mosi bit", 32'(mosi), 32'(e));
      end
   end

   task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   task automatic write_buf(input int w, input logic [31:0] d);
      bus_write(6'(8 + 4*w), d);
      for (int l = 0; l < 4; l++) tb_buf[4*w+l] = d[8*l +: 8];
   endtask

   function automatic int pick(input int j, input bit lsb);
      return lsb ? j : 7 - j;
   endfunction

   // driver: push the expected bit stream into the scoreboard queue
   task automatic push_stream(input logic [31:0] cmd, input int nc,
                              input int nw, input int nr, input bit lsb);
      for (int b = 0; b < nc; b++)
         exp_q.push_back(cmd[8*(3 - b/8) + pick(b%8, lsb)]);
      for (int b = 0; b < nw; b++)
         exp_q.push_back(b/8 < 32 ? tb_buf[b/8][pick(b%8, lsb)] : 1'b0);
      for (int b = 0; b < nr; b++) exp_q.push_back(1'b0);
   endtask

   task automatic model_read(input int nc, input int nw, input int nr,
                             input bit lsb);
      for (int r = 0; r < nr; r++) begin
         automatic int s = nc + nw + r;
         if (r/8 < 32) tb_buf[r/8][pick(r%8, lsb)] = slv_pat[63 - (s % 60)];
      end
   endtask

   task automatic check_buf(input string req);
      logic [31:0] d;
      for (int w = 0; w < 8; w++) begin
         bus_read(6'(8 + 4*w), d);
         check(d == {tb_buf[4*w+3], tb_buf[4*w+2], tb_buf[4*w+1], tb_buf[4*w]},
               req, $sformatf("buffer word %0d", w), d,
               {tb_buf[4*w+3], tb_buf[4*w+2], tb_buf[4*w+1], tb_buf[4*w]});
      end
   endtask

   task automatic run_xfer(input logic [31:0] cmd, input int nc, input int nw,
                           input int nr, input int dv, input bit lsb,
                           input bit poke, input string tag);
      int cnt;
      logic [31:0] d;
      cur_tag = tag;
      bus_write(6'h04, cmd);
      bus_write(6'h28, (32'(dv) << 16) | (32'(lsb) << 3));
      bus_write(6'h2C, (32'(nc) << 24) | (32'(nr) << 12) | 32'(nw));
      slv_clr = 1'b1; #1 slv_clr = 1'b0;
      push_stream(cmd, nc, nw, nr, lsb);
      bus_write(6'h00, 32'h100);
      bus_addr = 6'h00;
      #1 d = bus_rdata;
      // R3: busy set, start bit reads zero
      check(d == 32'h0001_0000, "R3", "control after start", d, 32'h0001_0000);
      cnt = 0;
      while (1) begin
         #1;
         if (!bus_rdata[16]) break;
         cnt++;
         @(negedge clk);
         bus_sel = 1'b0; bus_we = 1'b0; bus_addr = 6'h00;
         if (poke && cnt == 5) begin
            bus_sel = 1'b1; bus_we = 1'b1; bus_wdata = 32'h100;
         end
         if (cnt > 20000) break;
      end
      check(cnt == (nc + nw + nr) * (dv + 2), poke ? "R11" : "R8",
            "busy length", 32'(cnt), 32'((nc + nw + nr) * (dv + 2)));
      check(exp_q.size() == 0, tag, "bits left in scoreboard",
            32'(exp_q.size()), 32'h0);
      exp_q.delete();
      model_read(nc, nw, nr, lsb);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         check(1'b0, "R3", "watchdog expired", 32'h0, 32'h1);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      for (int i = 0; i < 32; i++) tb_buf[i] = '0;
      slv_clr = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1; slv_clr = 1'b0;

      // R1: reset state
      foreach (d[i]) ;
      for (int a = 0; a < 16; a++) begin
         bus_read(6'(4*a), d);
         check(d == 32'h0, "R1", $sformatf("reg 0x%0h after reset", 4*a), d, 32'h0);
      end
      check(cs_n == 2'b11 && sck == 1'b0 && mosi == 1'b0, "R1",
            "pins after reset", {29'h0, cs_n, sck}, 32'h6);

      // R2: readback
      write_buf(0, 32'h1234_5634);
      write_buf(1, 32'hDEAD_BEEF);
      for (int w = 2; w < 8; w++) write_buf(w, 32'h0101_0101 * w + 32'h80C0_E0F0);
      check_buf("R2");
      bus_write(6'h04, 32'hCAFE_F00D);
      bus_read(6'h04, d);
      check(d == 32'hCAFE_F00D, "R2", "command word readback", d, 32'hCAFE_F00D);
      bus_write(6'h28, 32'hFFFF_FFFF);
      bus_read(6'h28, d);
      // R9: only divider and bit-order bits are kept
      check(d == 32'h0FFF_0008, "R9", "config readback", d, 32'h0FFF_0008);
      bus_write(6'h2C, 32'h2010_0108);
      bus_read(6'h2C, d);
      check(d == 32'h2010_0108, "R4", "count readback", d, 32'h2010_0108);

      // R5 R6 R8: command then write data, msb first, period 2
      run_xfer(32'hA5C3_0F96, 8, 16, 0, 0, 1'b0, 1'b0, "R6");
      // R5 R7 R8: full command word then read, period 7
      run_xfer(32'h8142_24F1, 32, 0, 16, 5, 1'b0, 1'b0, "R5");
      check_buf("R7");
      // R9: lsb first on all three phases, period 3
      run_xfer(32'h6B00_0000, 8, 8, 8, 1, 1'b1, 1'b0, "R9");
      check_buf("R9");
      // R11: start while busy ignored
      run_xfer(32'h0, 0, 24, 0, 2, 1'b0, 1'b1, "R11");

      // R4: all counts zero, no transfer
      cur_tag = "R4";
      bus_write(6'h2C, 32'h0);
      bus_write(6'h00, 32'h100);
      repeat (4) @(negedge clk);
      bus_read(6'h00, d);
      check(d == 32'h0, "R4", "busy after empty start", d, 32'h0);

      // R12: selects
      bus_write(6'h38, 32'h1);
      check(cs_n == 2'b10, "R12", "cs_n select 0", 32'(cs_n), 32'h2);
      run_xfer(32'hFF00_0000, 8, 0, 0, 0, 1'b0, 1'b0, "R12");
      check(cs_n == 2'b10, "R12", "cs_n kept over transfer", 32'(cs_n), 32'h2);
      bus_write(6'h38, 32'h2);
      check(cs_n == 2'b01, "R12", "cs_n select 1", 32'(cs_n), 32'h1);
      bus_write(6'h38, 32'h0);
      check(cs_n == 2'b11, "R12", "cs_n released", 32'(cs_n), 32'h3);

      // R7 R13: read past the buffer end, no wrap; mosi low while reading
      run_xfer(32'h0, 0, 0, 264, 0, 1'b0, 1'b0, "R13");
      check_buf("R7");
      check(mosi == 1'b0 && sck == 1'b0, "R10", "idle pins", {30'h0, mosi, sck}, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule